// File: doc/BRIEF.md
# Runahead Mode Controller

This unit decides when a processor core abandons a full-window stall and pre-executes speculatively instead. The oldest instruction in the window may be blocked on a long-latency miss. If it is, and the unit is armed, the unit asks for a checkpoint of the architectural register state for one cycle and then enters runahead mode. In that mode it keeps one poison bit per architectural register. Each completing instruction reports its sources and destination. A result that depends on a poisoned register is poisoned in turn and the instruction is flagged to be dropped. A result computed only from clean registers clears its destination bit. A load whose address register is clean raises a prefetch request, and its result is never committed.

The unit captures the identifier of the blocking miss when it enters runahead. Only a miss return carrying that identifier ends the mode. The unit then spends one cycle asserting pipeline flush and checkpoint restore together, clears every poison bit and goes back to normal operation. The blocking instruction then executes again from the restored state. The unit stays disarmed until that instruction has retired, so the same miss cannot start a second runahead episode.

Top module: `rah_ctrl`

## Requirements
- R1: In normal mode, the unit enters the checkpoint state at the clock edge where `head_miss_valid` is high and the unit is armed. It is armed out of reset. While it is in normal mode with `head_miss_valid` low, `ckpt_save` stays 0.
- R2: `ckpt_save` is high for exactly one cycle, and runahead operation follows. `in_runahead` is high from the checkpoint cycle through the restore cycle, and low otherwise.
- R3: After the checkpoint cycle, `poison_vec` holds exactly one set bit, at index `head_miss_dst` as sampled on entry.
- R4: During runahead operation, a writeback is poisoned when a used source (`wb_src_a` with `wb_src_a_used`, `wb_src_b` with `wb_src_b_used`) has its poison bit set. A poisoned writeback raises `wb_drop` in the same cycle. When `wb_dst_valid` is high, the bit at `wb_dst` takes the poisoned value at the next edge. Sources that are not used have no effect.
- R5: During runahead operation, a writeback with `wb_is_load` high raises `pf_req` in the same cycle exactly when the poison bit of its address register `wb_src_a` is clear.
- R6: A miss return (`fill_valid`) whose `fill_id` differs from the identifier captured on entry does not end runahead.
- R7: A matching miss return during runahead operation leads to one restore cycle. In that cycle `ckpt_restore` and `pipe_flush` are both high. After it, `in_runahead` is low and `poison_vec` is all zero.
- R8: After a restore, the unit does not enter again while `head_miss_valid` is high. Re-entry becomes possible at the edge after a `head_retire` pulse in normal mode.
- R9: In normal mode, writebacks have no effect: `pf_req` and `wb_drop` stay 0 and `poison_vec` stays all zero. Reset leaves the unit in normal mode with all outputs 0.
- R10: A matching miss return during the checkpoint cycle leads straight to the restore cycle after the checkpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| head_miss_valid | input | 1 | Oldest window instruction is stalled on a long-latency miss |
| head_miss_id | input | ID_W | Identifier of that outstanding miss |
| head_miss_dst | input | REG_W | Destination register of the missing load |
| head_retire | input | 1 | Oldest instruction retired this cycle |
| fill_valid | input | 1 | A miss return arrives |
| fill_id | input | ID_W | Identifier of the returning miss |
| wb_valid | input | 1 | An instruction completes this cycle |
| wb_is_load | input | 1 | The completing instruction is a load |
| wb_src_a | input | REG_W | First source register (address register for loads) |
| wb_src_a_used | input | 1 | First source is read |
| wb_src_b | input | REG_W | Second source register |
| wb_src_b_used | input | 1 | Second source is read |
| wb_dst | input | REG_W | Destination register |
| wb_dst_valid | input | 1 | Instruction writes a destination |
| ckpt_save | output | 1 | Take an architectural checkpoint |
| ckpt_restore | output | 1 | Restore the checkpoint |
| pipe_flush | output | 1 | Flush the pipeline |
| in_runahead | output | 1 | Speculative mode indicator |
| pf_req | output | 1 | Issue a prefetch for the completing load |
| wb_drop | output | 1 | Completing instruction is poisoned and dropped |
| poison_vec | output | NUM_REGS | Per-register poison bits |

## Verification
The hardest situation to reach is a poison vector with many bits set in a varied pattern. Poison spreads only through chains of dependent writebacks that start from the single bit set on entry. The stimulus sweeps every destination register as the entry seed, and each episode then sends a burst of writebacks. In each burst the first instruction reads the seeded register, and the later ones mix used and unused sources, loads and non-writing instructions. The bench keeps its own poison model, derived from the propagation rule, and compares it with the output after every edge. Each episode also presents a non-matching return and then attempts a blocked re-entry before the retire pulse, so every destination register is tested under those rules too.

// File: rtl/rah_pkg.sv
package rah_pkg;

    typedef enum logic [1:0] {
        RAH_NORMAL = 2'd0,
        RAH_ENTER  = 2'd1,
        RAH_RUN    = 2'd2,
        RAH_EXIT   = 2'd3
    } rah_state_e;

endpackage

// File: rtl/rah_seq.sv
module rah_seq
    import rah_pkg::*;
#(
    parameter int ID_W  = 4,
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_miss_valid,
    input  logic [ID_W-1:0]  head_miss_id,
    input  logic [REG_W-1:0] head_miss_dst,
    input  logic             head_retire,
    input  logic             fill_valid,
    input  logic [ID_W-1:0]  fill_id,
    output rah_state_e       state_o,
    output logic [REG_W-1:0] seed_reg_o
);

    typedef struct packed {
        rah_state_e       state;
        logic             armed;
        logic [ID_W-1:0]  miss_id;
        logic [REG_W-1:0] seed;
    } seq_t;

    seq_t cur_q, cur_d;
    logic fill_hit;

    always_comb begin
        cur_d    = cur_q;
        fill_hit = fill_valid && (fill_id == cur_q.miss_id);
        unique case (cur_q.state)
            RAH_NORMAL: begin
                if (head_retire) begin
                    cur_d.armed = 1'b1;
                end
                if (head_miss_valid && cur_q.armed) begin
                    cur_d.state   = RAH_ENTER;
                    cur_d.miss_id = head_miss_id;
                    cur_d.seed    = head_miss_dst;
                end
            end
            RAH_ENTER: begin
                cur_d.state = fill_hit ? RAH_EXIT : RAH_RUN;
            end
            RAH_RUN: begin
                if (fill_hit) begin
                    cur_d.state = RAH_EXIT;
                end
            end
            RAH_EXIT: begin
                cur_d.state = RAH_NORMAL;
                cur_d.armed = 1'b0;
            end
            default: cur_d.state = RAH_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state   <= RAH_NORMAL;
            cur_q.armed   <= 1'b1;
            cur_q.miss_id <= '0;
            cur_q.seed    <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign state_o    = cur_q.state;
    assign seed_reg_o = cur_q.seed;

endmodule

// File: rtl/rah_poison.sv
module rah_poison
    import rah_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  rah_state_e          state_i,
    input  logic [REG_W-1:0]    seed_reg_i,
    input  logic                wb_valid,
    input  logic [REG_W-1:0]    wb_src_a,
    input  logic                wb_src_a_used,
    input  logic [REG_W-1:0]    wb_src_b,
    input  logic                wb_src_b_used,
    input  logic [REG_W-1:0]    wb_dst,
    input  logic                wb_dst_valid,
    output logic [NUM_REGS-1:0] vec_o,
    output logic                src_poison_o,
    output logic                addr_poison_o
);

    typedef struct packed {
        logic [NUM_REGS-1:0] vec;
    } pv_t;

    pv_t pv_q, pv_d;
    logic [NUM_REGS-1:0] run_next;
    logic                a_bad;
    logic                b_bad;

    always_comb begin
        a_bad         = pv_q.vec[wb_src_a];
        b_bad         = pv_q.vec[wb_src_b];
        src_poison_o  = (wb_src_a_used && a_bad) || (wb_src_b_used && b_bad);
        addr_poison_o = a_bad;
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_bit
        always_comb begin
            if (wb_valid && wb_dst_valid && (wb_dst == REG_W'(i))) begin
                run_next[i] = src_poison_o;
            end else begin
                run_next[i] = pv_q.vec[i];
            end
        end
    end

    always_comb begin
        pv_d = pv_q;
        unique case (state_i)
            RAH_ENTER: begin
                pv_d.vec             = '0;
                pv_d.vec[seed_reg_i] = 1'b1;
            end
            RAH_RUN:  pv_d.vec = run_next;
            default:  pv_d.vec = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pv_q.vec <= '0;
        end else begin
            pv_q <= pv_d;
        end
    end

    assign vec_o = pv_q.vec;

endmodule

// File: rtl/rah_out.sv
module rah_out
    import rah_pkg::*;
(
    input  rah_state_e state_i,
    input  logic       wb_valid,
    input  logic       wb_is_load,
    input  logic       src_poison_i,
    input  logic       addr_poison_i,
    output logic       ckpt_save,
    output logic       ckpt_restore,
    output logic       pipe_flush,
    output logic       in_runahead,
    output logic       pf_req,
    output logic       wb_drop
);

    logic running;

    always_comb begin
        running      = (state_i == RAH_RUN);
        ckpt_save    = (state_i == RAH_ENTER);
        ckpt_restore = (state_i == RAH_EXIT);
        pipe_flush   = (state_i == RAH_EXIT);
        in_runahead  = (state_i != RAH_NORMAL);
        wb_drop      = running && wb_valid && src_poison_i;
        pf_req       = running && wb_valid && wb_is_load && !addr_poison_i;
    end

endmodule

// File: rtl/rah_ctrl.sv
module rah_ctrl
    import rah_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int ID_W     = 4,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                head_miss_valid,
    input  logic [ID_W-1:0]     head_miss_id,
    input  logic [REG_W-1:0]    head_miss_dst,
    input  logic                head_retire,
    input  logic                fill_valid,
    input  logic [ID_W-1:0]     fill_id,
    input  logic                wb_valid,
    input  logic                wb_is_load,
    input  logic [REG_W-1:0]    wb_src_a,
    input  logic                wb_src_a_used,
    input  logic [REG_W-1:0]    wb_src_b,
    input  logic                wb_src_b_used,
    input  logic [REG_W-1:0]    wb_dst,
    input  logic                wb_dst_valid,
    output logic                ckpt_save,
    output logic                ckpt_restore,
    output logic                pipe_flush,
    output logic                in_runahead,
    output logic                pf_req,
    output logic                wb_drop,
    output logic [NUM_REGS-1:0] poison_vec
);

    rah_state_e       state;
    logic [REG_W-1:0] seed_reg;
    logic             src_poison;
    logic             addr_poison;

    rah_seq #(.ID_W(ID_W), .REG_W(REG_W)) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .head_miss_valid (head_miss_valid),
        .head_miss_id    (head_miss_id),
        .head_miss_dst   (head_miss_dst),
        .head_retire     (head_retire),
        .fill_valid      (fill_valid),
        .fill_id         (fill_id),
        .state_o         (state),
        .seed_reg_o      (seed_reg)
    );

    rah_poison #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_poison (
        .clk           (clk),
        .rst_n         (rst_n),
        .state_i       (state),
        .seed_reg_i    (seed_reg),
        .wb_valid      (wb_valid),
        .wb_src_a      (wb_src_a),
        .wb_src_a_used (wb_src_a_used),
        .wb_src_b      (wb_src_b),
        .wb_src_b_used (wb_src_b_used),
        .wb_dst        (wb_dst),
        .wb_dst_valid  (wb_dst_valid),
        .vec_o         (poison_vec),
        .src_poison_o  (src_poison),
        .addr_poison_o (addr_poison)
    );

    rah_out u_out (
        .state_i       (state),
        .wb_valid      (wb_valid),
        .wb_is_load    (wb_is_load),
        .src_poison_i  (src_poison),
        .addr_poison_i (addr_poison),
        .ckpt_save     (ckpt_save),
        .ckpt_restore  (ckpt_restore),
        .pipe_flush    (pipe_flush),
        .in_runahead   (in_runahead),
        .pf_req        (pf_req),
        .wb_drop       (wb_drop)
    );

endmodule

// File: rtl/rah_ctrl_chk.sv
module rah_ctrl_chk #(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                head_miss_valid,
    input logic                wb_valid,
    input logic                wb_dst_valid,
    input logic [REG_W-1:0]    wb_dst,
    input logic                ckpt_save,
    input logic                ckpt_restore,
    input logic                pipe_flush,
    input logic                in_runahead,
    input logic                pf_req,
    input logic                wb_drop,
    input logic [NUM_REGS-1:0] poison_vec
);

    logic run_phase;
    assign run_phase = in_runahead && !ckpt_save && !ckpt_restore;

    p_entry_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ckpt_save) |-> $past(head_miss_valid));

    p_save_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_save |=> !ckpt_save && in_runahead);

    p_seed_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_save |=> $countones(poison_vec) == 1);

    p_poison_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_phase && wb_valid && wb_dst_valid && wb_drop) |=> poison_vec[$past(wb_dst)]);

    p_poison_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_phase && wb_valid && wb_dst_valid && !wb_drop) |=> !poison_vec[$past(wb_dst)]);

    p_restore_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_restore |-> pipe_flush && in_runahead);

    p_restore_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_restore |=> !in_runahead && (poison_vec == '0));

    p_quiet_normal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_runahead |-> !pf_req && !wb_drop && (poison_vec == '0));

endmodule

bind rah_ctrl rah_ctrl_chk #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .head_miss_valid (head_miss_valid),
    .wb_valid        (wb_valid),
    .wb_dst_valid    (wb_dst_valid),
    .wb_dst          (wb_dst),
    .ckpt_save       (ckpt_save),
    .ckpt_restore    (ckpt_restore),
    .pipe_flush      (pipe_flush),
    .in_runahead     (in_runahead),
    .pf_req          (pf_req),
    .wb_drop         (wb_drop),
    .poison_vec      (poison_vec)
);

// File: tb/tb_rah_ctrl.sv
module tb_rah_ctrl;

    localparam int NR = 32;
    localparam int IW = 4;
    localparam int RW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic head_miss_valid = 1'b0;
    logic [IW-1:0] head_miss_id = '0;
    logic [RW-1:0] head_miss_dst = '0;
    logic head_retire = 1'b0;
    logic fill_valid = 1'b0;
    logic [IW-1:0] fill_id = '0;
    logic wb_valid = 1'b0;
    logic wb_is_load = 1'b0;
    logic [RW-1:0] wb_src_a = '0;
    logic wb_src_a_used = 1'b0;
    logic [RW-1:0] wb_src_b = '0;
    logic wb_src_b_used = 1'b0;
    logic [RW-1:0] wb_dst = '0;
    logic wb_dst_valid = 1'b0;
    logic ckpt_save, ckpt_restore, pipe_flush, in_runahead, pf_req, wb_drop;
    logic [NR-1:0] poison_vec;

    int n_chk = 0;
    int n_bad = 0;
    logic [NR-1:0] exp_v = '0;

    always #5 clk = ~clk;

    rah_ctrl #(.NUM_REGS(NR), .ID_W(IW)) dut (
        .clk (clk), .rst_n (rst_n),
        .head_miss_valid (head_miss_valid), .head_miss_id (head_miss_id),
        .head_miss_dst (head_miss_dst), .head_retire (head_retire),
        .fill_valid (fill_valid), .fill_id (fill_id),
        .wb_valid (wb_valid), .wb_is_load (wb_is_load),
        .wb_src_a (wb_src_a), .wb_src_a_used (wb_src_a_used),
        .wb_src_b (wb_src_b), .wb_src_b_used (wb_src_b_used),
        .wb_dst (wb_dst), .wb_dst_valid (wb_dst_valid),
        .ckpt_save (ckpt_save), .ckpt_restore (ckpt_restore),
        .pipe_flush (pipe_flush), .in_runahead (in_runahead),
        .pf_req (pf_req), .wb_drop (wb_drop), .poison_vec (poison_vec)
    );

    task automatic check(input bit ok, input string req, input logic [NR-1:0] act,
                         input logic [NR-1:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic enter(input logic [RW-1:0] d, input logic [IW-1:0] id);
        head_miss_valid = 1'b1;
        head_miss_id    = id;
        head_miss_dst   = d;
        #1;
        check(ckpt_save == 1'b0, "R1 no save before edge", NR'(ckpt_save), '0);
        tick();
        head_miss_valid = 1'b0;
        #1;
        check(ckpt_save && in_runahead, "R2 save cycle", NR'({ckpt_save, in_runahead}), NR'(3));
        tick();
        #1;
        check(!ckpt_save && in_runahead, "R2 running after save", NR'({ckpt_save, in_runahead}), NR'(1));
        exp_v = '0;
        exp_v[d] = 1'b1;
        check(poison_vec == exp_v, "R3 seed vector", poison_vec, exp_v);
    endtask

    task automatic leave(input logic [IW-1:0] id);
        fill_valid = 1'b1;
        fill_id    = id;
        tick();
        fill_valid = 1'b0;
        #1;
        check(ckpt_restore && pipe_flush, "R7 restore and flush", NR'({ckpt_restore, pipe_flush}), NR'(3));
        tick();
        #1;
        exp_v = '0;
        check(!in_runahead && !ckpt_restore && poison_vec == '0, "R7 back to normal",
              poison_vec | NR'({in_runahead, ckpt_restore}) << 0, '0);
    endtask

    task automatic wb_op(input logic [RW-1:0] a, input bit ua, input logic [RW-1:0] b, input bit ub,
                         input logic [RW-1:0] d, input bit dv, input bit ld, input bit normal);
        bit pois;
        wb_valid = 1'b1; wb_src_a = a; wb_src_a_used = ua; wb_src_b = b; wb_src_b_used = ub;
        wb_dst = d; wb_dst_valid = dv; wb_is_load = ld;
        #1;
        pois = (ua && exp_v[a]) || (ub && exp_v[b]);
        if (normal) begin
            check(!wb_drop && !pf_req, "R9 no drop or prefetch in normal", NR'({wb_drop, pf_req}), '0);
        end else begin
            check(wb_drop == pois, "R4 drop flag", NR'(wb_drop), NR'(pois));
            check(pf_req == (ld && !exp_v[a]), "R5 prefetch", NR'(pf_req), NR'(ld && !exp_v[a]));
        end
        tick();
        wb_valid = 1'b0;
        if (!normal && dv) exp_v[d] = pois;
        #1;
        check(poison_vec == exp_v, normal ? "R9 vector untouched" : "R4 vector update", poison_vec, exp_v);
    endtask

    task automatic retire();
        head_retire     = 1'b1;
        head_miss_valid = 1'b0;
        tick();
        head_retire = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check({ckpt_save, ckpt_restore, pipe_flush, in_runahead, pf_req, wb_drop} == '0 && poison_vec == '0,
              "R9 reset state", poison_vec, '0);
        rst_n = 1'b1;
        tick();
        // R9: normal-mode writebacks are ignored
        for (int k = 0; k < 8; k++) begin
            wb_op(RW'(k), 1'b1, RW'(k + 3), 1'b1, RW'(k * 3), 1'b1, k[0], 1'b1);
        end
        // sweep every seed register
        for (int d = 0; d < NR; d++) begin
            enter(RW'(d), IW'(d));
            for (int k = 0; k < 8; k++) begin
                int x;
                x = d * 8 + k;
                wb_op(k == 0 ? RW'(d) : RW'(x * 7 + d), (k == 0) || x[0] || x[2],
                      RW'(x * 11 + 5), x[1],
                      RW'(x * 13 + 3), (x % 5) != 0, x[2] || (k == 0), 1'b0);
            end
            // R6: other miss ids are ignored
            fill_valid = 1'b1;
            fill_id    = IW'(d) ^ IW'(1);
            tick();
            fill_valid = 1'b0;
            #1;
            check(in_runahead && !ckpt_restore, "R6 foreign fill ignored",
                  NR'({in_runahead, ckpt_restore}), NR'(2));
            check(poison_vec == exp_v, "R6 vector kept", poison_vec, exp_v);
            leave(IW'(d));
            // R8: no re-entry before retire
            head_miss_valid = 1'b1;
            tick();
            tick();
            #1;
            check(!ckpt_save && !in_runahead, "R8 blocked before retire", NR'({ckpt_save, in_runahead}), '0);
            retire();
        end
        // R8: after retire, entry is allowed again
        head_miss_valid = 1'b1;
        head_miss_id    = 4'd9;
        head_miss_dst   = 5'd7;
        tick();
        #1;
        check(ckpt_save, "R8 re-entry after retire", NR'(ckpt_save), NR'(1));
        // R10: matching return during the checkpoint cycle
        head_miss_valid = 1'b0;
        fill_valid = 1'b1;
        fill_id    = 4'd9;
        tick();
        fill_valid = 1'b0;
        #1;
        check(ckpt_restore && pipe_flush, "R10 fill in save cycle", NR'({ckpt_restore, pipe_flush}), NR'(3));
        tick();
        #1;
        check(!in_runahead && poison_vec == '0, "R10 normal again", poison_vec, '0);
        retire();
        // R1: missing-head flag low keeps the unit in normal mode
        tick();
        tick();
        #1;
        check(!ckpt_save && !in_runahead, "R1 idle without miss", NR'({ckpt_save, in_runahead}), '0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule